// File: doc/BRIEF.md
# Atomic Fetch-and-Operate Memory Unit

This unit carries out one load-atomic operation against a single-port synchronous memory. A request supplies a byte address, a 64-bit operand, a 5-bit function code and a size flag (word or doubleword). The unit reads the old contents and combines them with the operand. It writes the combined value back and returns the old contents. While it is busy, no other request can slip between its read and its write.

Two kinds of request fault without any memory access: a function code outside the supported set, and an address that is not naturally aligned to the access size. The fault response is a 2-bit cause code delivered with the done pulse. The memory is 64 bits wide and is addressed by doubleword index. A word access works on one 32-bit lane of that doubleword and leaves the other lane as it was.

Top module: `fetch_op_atom_unit`

## Requirements
- R1: Function code 0 adds the operand to the old value and stores the sum. The sum wraps modulo 2^32 for a word and modulo 2^64 for a doubleword, and no carry leaves the lane.
- R2: Function code 1 stores old XOR operand, code 2 stores old OR operand, and code 3 stores old AND operand.
- R3: Function code 8 stores the operand unchanged (swap).
- R4: `result` carries the old memory value. A word result is zero-extended to 64 bits. For a word access only bits 31:0 of the operand are used.
- R5: A word access works on bits 31:0 of the addressed doubleword when address bit 2 is 0, and on bits 63:32 when it is 1. The other half is written back unchanged.
- R6: Any function code other than 0, 1, 2, 3 or 8 finishes with `done` and `fault` = 2'b01. The request makes no memory access, and `result` is 0.
- R7: A doubleword address with bits 2:0 not zero, or a word address with bits 1:0 not zero, finishes with `done` and `fault` = 2'b10 and makes no memory access. An invalid code takes priority over misalignment.
- R8: Suppose a request is accepted on a clock edge. In the next cycle the memory is read (`mem_en`=1, `mem_we`=0). In the cycle after that it is written at the same index. `done` pulses in the following cycle with `fault`=0. A faulting request pulses `done` in the cycle right after it is accepted.
- R9: `busy` is high from acceptance until the write cycle ends. A `req_valid` seen while busy is ignored: it produces no done and no memory change.
- R10: After reset, `busy`, `done`, `fault` and `mem_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_fc | input | 5 | Function code |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_addr | input | AW | Byte address |
| req_operand | input | 64 | Operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 01 invalid code, 10 misaligned, valid with done |
| result | output | 64 | Old memory value, valid with done |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW-3 | Doubleword index |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read |

## Verification
Each supported code is tried on both sizes and both word lanes. The test values are chosen so that XOR, OR and AND give different results, and so that add carries across bit 31. This shows word wrap apart from a doubleword carry. An operand with nonzero upper bits shows that a word access ignores them, and a preset neighbour lane shows that it survives the merge. Faulting requests use invalid codes, misaligned addresses for each size, and a request that has both errors. This last case separates the priority order. A count of memory cycles confirms that a fault causes no access. A request held during a busy operation must leave both a second doubleword and the done count untouched.

// File: rtl/fetch_op_atom_unit.sv
module fetch_op_atom_unit #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [4:0]    req_fc,
  input  logic          req_dword,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_operand,
  output logic          busy,
  output logic          done,
  output logic [1:0]    fault,
  output logic [63:0]   result,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-4:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;

  state_t        state;
  logic [4:0]    fc_q;
  logic          dw_q;
  logic [AW-1:2] addr_q;
  logic [63:0]   opnd_q;

  logic          code_ok, misal;
  logic [1:0]    req_flt;
  logic [63:0]   old_lane, opnd_lane, new_lane;

  assign code_ok = (req_fc[4:2] == 3'b000) || (req_fc == 5'd8);
  assign misal   = req_dword ? (req_addr[2:0] != 3'b000) : (req_addr[1:0] != 2'b00);
  assign req_flt = !code_ok ? 2'b01 : (misal ? 2'b10 : 2'b00);

  assign old_lane  = dw_q ? mem_rdata
                          : {32'b0, (addr_q[2] ? mem_rdata[63:32] : mem_rdata[31:0])};
  assign opnd_lane = dw_q ? opnd_q : {32'b0, opnd_q[31:0]};

  always_comb begin
    case (fc_q)
      5'd0:    new_lane = old_lane + opnd_lane;
      5'd1:    new_lane = old_lane ^ opnd_lane;
      5'd2:    new_lane = old_lane | opnd_lane;
      5'd3:    new_lane = old_lane & opnd_lane;
      default: new_lane = opnd_lane;
    endcase
  end

  assign mem_wdata = dw_q     ? new_lane :
                     addr_q[2] ? {new_lane[31:0], mem_rdata[31:0]}
                               : {mem_rdata[63:32], new_lane[31:0]};

  assign busy     = (state != S_IDLE);
  assign mem_en   = (state != S_IDLE);
  assign mem_we   = (state == S_WR);
  assign mem_addr = addr_q[AW-1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fc_q   <= '0;
      dw_q   <= 1'b0;
      addr_q <= '0;
      opnd_q <= '0;
      done   <= 1'b0;
      fault  <= 2'b00;
      result <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 2'b00;
      case (state)
        S_IDLE: if (req_valid) begin
          fc_q   <= req_fc;
          dw_q   <= req_dword;
          addr_q <= req_addr[AW-1:2];
          opnd_q <= req_operand;
          if (req_flt != 2'b00) begin
            done   <= 1'b1;
            fault  <= req_flt;
            result <= '0;
          end else begin
            state <= S_RD;
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          done   <= 1'b1;
          result <= old_lane;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fetch_op_atom_chk.sv
module fetch_op_atom_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    fault,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-4:0] mem_addr
);
  // R8
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_en) && !$past(mem_we)));
  // R8
  wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (done && fault == 2'b00));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(mem_addr));
  // R6
  fault_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'b00) |-> (!mem_en && !$past(mem_en)));
  // R7
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 2'b00) |-> (done && fault != 2'b11));
  // R9
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

bind fetch_op_atom_unit fetch_op_atom_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_fetch_op_atom_unit.sv
module tb_fetch_op_atom_unit;
  localparam int AW = 8;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [4:0]    req_fc = '0;
  logic          req_dword = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_operand = '0;
  logic          busy, done, mem_en, mem_we;
  logic [1:0]    fault;
  logic [63:0]   result, mem_wdata;
  logic [63:0]   mem_rdata;
  logic [AW-4:0] mem_addr;

  logic          pl_en = 1'b0;
  logic [AW-4:0] pl_addr = '0;
  logic [63:0]   pl_data = '0;
  logic [63:0]   mem [32];

  int checks = 0, fails = 0, en_cnt = 0, done_cnt = 0, cycles = 0;

  always #2 clk = ~clk;

  fetch_op_atom_unit #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fc(req_fc),
    .req_dword(req_dword), .req_addr(req_addr), .req_operand(req_operand),
    .busy(busy), .done(done), .fault(fault), .result(result),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (pl_en) mem[pl_addr] <= pl_data;
    else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (mem_en) en_cnt = en_cnt + 1;
    if (done) done_cnt = done_cnt + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  // {fc, dword, addr, operand, initial mem, expected result, expected mem, fault}
  localparam logic [271:0] VEC [NV] = '{
    {5'd0, 1'b1, 8'h08, 64'h0000_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b00},
    {5'd0, 1'b0, 8'h10, 64'h1234_5678_0000_0003, 64'hAAAA_AAAA_FFFF_FFFE, 64'h0000_0000_FFFF_FFFE, 64'hAAAA_AAAA_0000_0001, 2'b00},
    {5'd1, 1'b1, 8'h18, 64'hFFFF_0000_FFFF_0000, 64'hF0F0_F0F0_0F0F_0F0F, 64'hF0F0_F0F0_0F0F_0F0F, 64'h0F0F_F0F0_F0F0_0F0F, 2'b00},
    {5'd2, 1'b0, 8'h24, 64'h0000_0000_0000_0110, 64'h1000_0001_5555_5555, 64'h0000_0000_1000_0001, 64'h1000_0111_5555_5555, 2'b00},
    {5'd3, 1'b1, 8'h30, 64'h0F0F_0F0F_0F0F_0F0F, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 64'h0204_0608_0A0C_0E00, 2'b00},
    {5'd8, 1'b0, 8'h38, 64'hFFFF_FFFF_0BAD_F00D, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_CAFE_F00D, 64'hDEAD_BEEF_0BAD_F00D, 2'b00},
    {5'd8, 1'b1, 8'h40, 64'h7654_3210_FEDC_BA98, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h7654_3210_FEDC_BA98, 2'b00},
    {5'd4, 1'b1, 8'h48, 64'h0000_0000_0000_0001, 64'h1111_1111_1111_1111, 64'h0,                   64'h1111_1111_1111_1111, 2'b01},
    {5'd31,1'b0, 8'h50, 64'h0000_0000_0000_0001, 64'h2222_2222_2222_2222, 64'h0,                   64'h2222_2222_2222_2222, 2'b01},
    {5'd0, 1'b1, 8'h5C, 64'h0000_0000_0000_0001, 64'h3333_3333_3333_3333, 64'h0,                   64'h3333_3333_3333_3333, 2'b10},
    {5'd2, 1'b0, 8'h61, 64'h0000_0000_0000_00FF, 64'h4444_4444_4444_4444, 64'h0,                   64'h4444_4444_4444_4444, 2'b10},
    {5'd9, 1'b0, 8'h63, 64'h0000_0000_0000_0001, 64'h5555_5555_5555_5555, 64'h0,                   64'h5555_5555_5555_5555, 2'b01},
    {5'd3, 1'b0, 8'h6C, 64'hFFFF_FFFF_0000_000F, 64'h0000_00FF_ABCD_0000, 64'h0000_0000_0000_00FF, 64'h0000_000F_ABCD_0000, 2'b00},
    {5'd0, 1'b0, 8'h74, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0005, 2'b00}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [AW-4:0] a, input logic [63:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic run_op(input logic [4:0] fc, input logic dw, input logic [AW-1:0] a,
                        input logic [63:0] op, output logic [63:0] res,
                        output logic [1:0] flt, output int cyc);
    @(negedge clk);
    en_cnt = 0;
    req_valid = 1'b1; req_fc = fc; req_dword = dw; req_addr = a; req_operand = op;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 10) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    res = result;
    flt = fault;
  endtask

  initial begin
    logic [63:0] res;
    logic [1:0]  flt;
    int          cyc;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && fault == 2'b00 && !mem_en, "R10 reset outputs",
        {60'b0, busy, done, mem_en, |fault}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [271:0] v;
      v = VEC[i];
      preload(v[265:261], v[193:130]);
      run_op(v[271:267], v[266], v[265:258], v[257:194], res, flt, cyc);
      // R4 returned old value, R6/R7 fault code
      chk(res == v[129:66], $sformatf("R4 result vec %0d", i), res, v[129:66]);
      chk(flt == v[1:0], $sformatf("R6/R7 fault vec %0d", i), {62'b0, flt}, {62'b0, v[1:0]});
      // R1/R2/R3/R5 memory contents after the operation
      chk(mem[v[265:261]] == v[65:2], $sformatf("R1/R2/R3/R5 memory vec %0d", i),
          mem[v[265:261]], v[65:2]);
      // R8 timing and access count; R6/R7 no access on fault
      if (v[1:0] == 2'b00) begin
        chk(cyc == 3, $sformatf("R8 done latency vec %0d", i), cyc, 3);
        chk(en_cnt == 2, $sformatf("R8 memory cycles vec %0d", i), en_cnt, 2);
      end else begin
        chk(cyc == 1, $sformatf("R6/R7 fault latency vec %0d", i), cyc, 1);
        chk(en_cnt == 0, $sformatf("R6/R7 no memory access vec %0d", i), en_cnt, 0);
      end
    end

    // R9: request during busy is ignored
    preload(5'd16, 64'h5555_5555_5555_5555);
    preload(5'd17, 64'h0000_0000_0000_0001);
    @(negedge clk);
    done_cnt = 0;
    req_valid = 1'b1; req_fc = 5'd0; req_dword = 1'b1; req_addr = 8'h88; req_operand = 64'h1;
    @(negedge clk);
    chk(busy && mem_en && !mem_we, "R8 read cycle after accept",
        {61'b0, busy, mem_en, mem_we}, 64'h6);
    req_fc = 5'd8; req_addr = 8'h80; req_operand = 64'h0;
    @(negedge clk);
    chk(busy && mem_we, "R9 busy through write cycle", {62'b0, busy, mem_we}, 64'h3);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    chk(mem[16] == 64'h5555_5555_5555_5555, "R9 second index untouched",
        mem[16], 64'h5555_5555_5555_5555);
    chk(mem[17] == 64'h2, "R9 first operation completed", mem[17], 64'h2);
    chk(!busy && !mem_en, "R9 idle afterwards", {62'b0, busy, mem_en}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule